// File: doc/BRIEF.md
# Packet Header and Parity Register

This unit sits on the datapath of a router that has one byte-wide input and three output queues. A packet is a header byte, then 1 to 63 payload bytes, then a single parity byte. The header carries the destination queue in its two low bits and the payload length in the upper six. A separate controller steps through a fixed sequence of states and tells the unit what to do with one strobe per state: decode the header, emit the first byte, load payload, or resume after the selected queue was full. The unit drives the byte that is written into the selected queue on `dout`.

The unit latches the header and sends it out in the first-byte state. It passes payload bytes straight through while the queue has room. A byte that arrives while the queue is full is kept in a one-deep hold register and sent out in the resume state. Alongside this it keeps a running XOR of the header and payload bytes and captures the parity byte sent by the source. Once the parity byte is in, it flags a mismatch on `err`. Two more flags go back to the controller: `short_pkt` marks that the input's valid signal dropped during the load state, and `par_done` marks that the parity byte has been taken.

Top module: `pkt_hdr_parity_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `dout` at 0 and `err`, `short_pkt` and `par_done` low.
- R2: A byte on `din` at an edge with `st_decode` and `pkt_vld` both high, and with bits [1:0] not equal to 2'b11, is captured as the header. That header appears on `dout` one edge after an edge where `st_first` is high.
- R3: At an edge where `st_load` is high and `q_full` is low, `din` appears on `dout` after that edge. This includes the parity byte, which is the byte presented while `pkt_vld` is low.
- R4: At an edge where `st_load` and `q_full` are both high, the byte on `din` goes into the hold register and `dout` does not take it. After the next edge where `st_resume` is high, `dout` shows the held byte, whatever `din` is at that time.
- R5: The computed parity is cleared by `st_decode` and seeded with the header at `st_first`. Every payload byte is XORed into it, including bytes that went through the hold register. While `par_done` is high, `err` updates on each edge to show whether the received parity byte differs from the computed parity. `err` clears at an edge where `st_decode` is high, so a correct packet leaves it low.
- R6: `short_pkt` is set at an edge where `st_load` is high and `pkt_vld` is low. It is cleared at an edge where `st_clr_short` is high, and the clear takes priority.
- R7: `par_done` is set at an edge where `st_load` is high and both `q_full` and `pkt_vld` are low. It is also set at an edge where `st_resume` and `short_pkt` are high while `par_done` is low. It stays low while the parity byte is only held. It clears at an edge where `st_decode` is high, and that clear takes priority.
- R8: A byte seen in the decode state with address bits [1:0] equal to 2'b11, or with `pkt_vld` low, does not replace the latched header. The next first-byte state emits the previous header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Incoming packet byte |
| pkt_vld | input | 1 | High while header and payload bytes are presented; low for the parity byte |
| q_full | input | 1 | The selected output queue is full |
| st_decode | input | 1 | Controller is in the header-decode state |
| st_first | input | 1 | Controller is in the first-byte (header emit) state |
| st_load | input | 1 | Controller is in the payload load state |
| st_resume | input | 1 | Controller is resuming after a full queue (emit held byte) |
| st_clr_short | input | 1 | Clear strobe for `short_pkt` |
| dout | output | 8 | Byte toward the selected queue |
| err | output | 1 | Received parity differs from computed parity |
| short_pkt | output | 1 | Packet ended during the load state |
| par_done | output | 1 | Parity byte has been taken |

## Verification
The bench stalls the queue on payload bytes in the middle and at the end of a packet, and on the parity byte itself. A design that dropped the held byte, sent out `din` in the resume state, or left the held byte out of the parity would show a wrong `dout` or a false `err`. When the parity byte is held, `par_done` must stay low until the resume state. A design that set it on the held parity byte would let the controller check parity before the byte was captured. The bench also sends reserved-address and non-valid decode bytes, which must not overwrite the header. It checks that `err` left over from a corrupt packet is cleared by the next decode and by reset.

// File: rtl/pkt_reg_pkg.sv
package pkt_reg_pkg;

    parameter int unsigned BYTE_W = 8;
    parameter int unsigned ADDR_W = 2;
    localparam int unsigned LEN_W = BYTE_W - ADDR_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // Contents of the one-deep hold register used under back-pressure
    typedef struct packed {
        byte_t data;
        logic  is_par;   // held byte is the packet parity byte
        logic  vld;      // hold register occupied
    } held_t;

    // The all-ones address is reserved and never names a queue
    function automatic logic addr_usable(input byte_t hdr);
        return hdr[ADDR_W-1:0] != {ADDR_W{1'b1}};
    endfunction

endpackage

// File: rtl/phr_hdr_latch.sv
module phr_hdr_latch
    import pkt_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  st_decode,
    input  logic  pkt_vld,
    input  byte_t din,
    output byte_t hdr
);

    logic take;

    always_comb begin
        take = st_decode && pkt_vld && addr_usable(din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (take) begin
            hdr <= din;
        end
    end

endmodule

// File: rtl/phr_hold_reg.sv
module phr_hold_reg
    import pkt_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  st_load,
    input  logic  st_resume,
    input  logic  pkt_vld,
    input  logic  q_full,
    input  byte_t din,
    output held_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (st_load && q_full) begin
            held.data   <= din;
            held.is_par <= !pkt_vld;
            held.vld    <= 1'b1;
        end else if (st_resume) begin
            held.vld    <= 1'b0;
        end
    end

endmodule

// File: rtl/phr_out_sel.sv
module phr_out_sel
    import pkt_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  st_first,
    input  logic  st_load,
    input  logic  st_resume,
    input  logic  q_full,
    input  byte_t din,
    input  byte_t hdr,
    input  held_t held,
    output byte_t dout
);

    typedef enum logic [1:0] {SRC_KEEP, SRC_HDR, SRC_DIN, SRC_HELD} src_e;

    src_e src;

    always_comb begin
        src = SRC_KEEP;
        if (st_first) begin
            src = SRC_HDR;
        end else if (st_load && !q_full) begin
            src = SRC_DIN;
        end else if (st_resume && held.vld) begin
            src = SRC_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            case (src)
                SRC_HDR:  dout <= hdr;
                SRC_DIN:  dout <= din;
                SRC_HELD: dout <= held.data;
                default:  dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/phr_flags.sv
module phr_flags (
    input  logic clk,
    input  logic rst,
    input  logic st_decode,
    input  logic st_load,
    input  logic st_resume,
    input  logic st_clr_short,
    input  logic pkt_vld,
    input  logic q_full,
    output logic short_pkt,
    output logic par_done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            short_pkt <= 1'b0;
        end else if (st_clr_short) begin
            short_pkt <= 1'b0;
        end else if (st_load && !pkt_vld) begin
            short_pkt <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_done <= 1'b0;
        end else if (st_decode) begin
            par_done <= 1'b0;
        end else if (st_load && !q_full && !pkt_vld) begin
            par_done <= 1'b1;
        end else if (st_resume && short_pkt && !par_done) begin
            par_done <= 1'b1;
        end
    end

endmodule

// File: rtl/phr_parity.sv
module phr_parity
    import pkt_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  st_decode,
    input  logic  st_first,
    input  logic  st_load,
    input  logic  st_resume,
    input  logic  pkt_vld,
    input  logic  q_full,
    input  logic  par_done,
    input  byte_t din,
    input  byte_t hdr,
    input  held_t held,
    output logic  err
);

    byte_t calc_q;
    byte_t rx_q;
    logic  pay_now, par_now, pay_held, par_held;

    always_comb begin
        pay_now  = st_load && !q_full && pkt_vld;
        par_now  = st_load && !q_full && !pkt_vld;
        pay_held = st_resume && held.vld && !held.is_par;
        par_held = st_resume && held.vld && held.is_par;
    end

    always_ff @(posedge clk) begin
        if (rst || st_decode) begin
            calc_q <= '0;
        end else if (st_first) begin
            calc_q <= hdr;
        end else if (pay_now) begin
            calc_q <= calc_q ^ din;
        end else if (pay_held) begin
            calc_q <= calc_q ^ held.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (par_now) begin
            rx_q <= din;
        end else if (par_held) begin
            rx_q <= held.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || st_decode) begin
            err <= 1'b0;
        end else if (par_done) begin
            err <= (rx_q != calc_q);
        end
    end

endmodule

// File: rtl/pkt_hdr_parity_reg.sv
module pkt_hdr_parity_reg
    import pkt_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] din,
    input  logic              pkt_vld,
    input  logic              q_full,
    input  logic              st_decode,
    input  logic              st_first,
    input  logic              st_load,
    input  logic              st_resume,
    input  logic              st_clr_short,
    output logic [BYTE_W-1:0] dout,
    output logic              err,
    output logic              short_pkt,
    output logic              par_done
);

    byte_t hdr;
    held_t held;

    phr_hdr_latch u_hdr (
        .clk(clk), .rst(rst), .st_decode(st_decode), .pkt_vld(pkt_vld),
        .din(din), .hdr(hdr)
    );

    phr_hold_reg u_hold (
        .clk(clk), .rst(rst), .st_load(st_load), .st_resume(st_resume),
        .pkt_vld(pkt_vld), .q_full(q_full), .din(din), .held(held)
    );

    phr_out_sel u_out (
        .clk(clk), .rst(rst), .st_first(st_first), .st_load(st_load),
        .st_resume(st_resume), .q_full(q_full), .din(din), .hdr(hdr),
        .held(held), .dout(dout)
    );

    phr_flags u_flags (
        .clk(clk), .rst(rst), .st_decode(st_decode), .st_load(st_load),
        .st_resume(st_resume), .st_clr_short(st_clr_short),
        .pkt_vld(pkt_vld), .q_full(q_full),
        .short_pkt(short_pkt), .par_done(par_done)
    );

    phr_parity u_par (
        .clk(clk), .rst(rst), .st_decode(st_decode), .st_first(st_first),
        .st_load(st_load), .st_resume(st_resume), .pkt_vld(pkt_vld),
        .q_full(q_full), .par_done(par_done), .din(din), .hdr(hdr),
        .held(held), .err(err)
    );

endmodule

// File: rtl/phr_checker.sv
module phr_checker
    import pkt_reg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] din,
    input logic              pkt_vld,
    input logic              q_full,
    input logic              st_decode,
    input logic              st_first,
    input logic              st_load,
    input logic              st_resume,
    input logic              st_clr_short,
    input logic [BYTE_W-1:0] dout,
    input logic              err,
    input logic              short_pkt,
    input logic              par_done
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (dout == '0 && !err && !short_pkt && !par_done)); // R1

    AST_HDR_EMIT: assert property (@(posedge clk) disable iff (rst)
        (st_decode && pkt_vld && din[ADDR_W-1:0] != {ADDR_W{1'b1}}) ##1 st_first
        |=> dout == $past(din, 2)); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (st_load && !q_full) |=> dout == $past(din)); // R3

    AST_HELD_EMIT: assert property (@(posedge clk) disable iff (rst)
        (st_load && q_full && !st_first) ##1 (st_resume && !st_first && !st_load)
        |=> dout == $past(din, 2)); // R4

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st_decode |=> !err); // R5

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(par_done)); // R5

    AST_SHORT_SET: assert property (@(posedge clk) disable iff (rst)
        (st_load && !pkt_vld && !st_clr_short) |=> short_pkt); // R6

    AST_SHORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st_clr_short |=> !short_pkt); // R6

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        (st_load && !q_full && !pkt_vld && !st_decode) |=> par_done); // R7

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st_decode |=> !par_done); // R7

endmodule

bind pkt_hdr_parity_reg phr_checker u_chk (
    .clk(clk), .rst(rst), .din(din), .pkt_vld(pkt_vld), .q_full(q_full),
    .st_decode(st_decode), .st_first(st_first), .st_load(st_load),
    .st_resume(st_resume), .st_clr_short(st_clr_short), .dout(dout),
    .err(err), .short_pkt(short_pkt), .par_done(par_done)
);

// File: tb/sim_pkt_hdr_parity_reg.sv
module sim_pkt_hdr_parity_reg;
    import pkt_reg_pkg::*;

    logic  clk = 1'b0;
    logic  rst;
    byte_t din;
    logic  pkt_vld, q_full;
    logic  st_decode, st_first, st_load, st_resume, st_clr_short;
    byte_t dout;
    logic  err, short_pkt, par_done;

    int n_chk  = 0;
    int n_fail = 0;
    byte_t exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pkt_hdr_parity_reg u0 (
        .clk(clk), .rst(rst), .din(din), .pkt_vld(pkt_vld), .q_full(q_full),
        .st_decode(st_decode), .st_first(st_first), .st_load(st_load),
        .st_resume(st_resume), .st_clr_short(st_clr_short),
        .dout(dout), .err(err), .short_pkt(short_pkt), .par_done(par_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares every byte the driver scheduled for this edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {24'd0, dout}, {24'd0, exp_q.pop_front()});
        end
    end

    // Driver: one controller cycle; optionally schedules an expected dout byte
    task automatic cyc(input logic dec, input logic fst, input logic ld,
                       input logic res, input logic clr, input logic vld,
                       input logic full, input byte_t d,
                       input bit push, input byte_t exp, input string tag);
        @(negedge clk);
        st_decode = dec; st_first = fst; st_load = ld;
        st_resume = res; st_clr_short = clr;
        pkt_vld = vld; q_full = full; din = d;
        if (push) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "");
    endtask

    task automatic send_pkt(input logic [1:0] addr, input int len,
                            input int stall, input bit par_full, input bit corrupt);
        byte_t hdr, par;
        byte_t p[64];
        hdr = {len[5:0], addr};
        par = hdr;
        for (int i = 0; i < len; i++) begin
            p[i] = 8'(i * 37 + addr * 5 + len);
            par  = par ^ p[i];
        end
        if (corrupt) par = par ^ 8'h10;

        cyc(1, 0, 0, 0, 0, 1, 0, hdr, 0, 8'h00, "");
        check("R5 err cleared by decode", {31'd0, err}, 32'd0);
        check("R7 par_done cleared by decode", {31'd0, par_done}, 32'd0);
        cyc(0, 1, 0, 0, 0, 1, 0, p[0], 1, hdr, "R2 header emit");
        for (int i = 0; i < len; i++) begin
            if (i == stall) begin
                cyc(0, 0, 1, 0, 0, 1, 1, p[i], 0, 8'h00, "");
                cyc(0, 0, 0, 1, 0, 1, 0, 8'hA5, 1, p[i], "R4 held payload");
            end else begin
                cyc(0, 0, 1, 0, 0, 1, 0, p[i], 1, p[i], "R3 payload pass");
            end
        end
        if (par_full) begin
            cyc(0, 0, 1, 0, 0, 0, 1, par, 0, 8'h00, "");
            check("R6 short set with parity held", {31'd0, short_pkt}, 32'd1);
            check("R7 par_done low while parity held", {31'd0, par_done}, 32'd0);
            cyc(0, 0, 0, 1, 0, 0, 0, 8'h00, 1, par, "R4 held parity");
        end else begin
            cyc(0, 0, 1, 0, 0, 0, 0, par, 1, par, "R3 parity pass");
        end
        idle();
        check("R7 par_done set", {31'd0, par_done}, 32'd1);
        check("R5 err vs received parity", {31'd0, err}, {31'd0, corrupt});
        check("R6 short_pkt set", {31'd0, short_pkt}, 32'd1);
        cyc(0, 0, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, "");
        check("R6 short_pkt cleared", {31'd0, short_pkt}, 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; din = '0; pkt_vld = 0; q_full = 0;
        st_decode = 0; st_first = 0; st_load = 0; st_resume = 0; st_clr_short = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset dout", {24'd0, dout}, 32'd0);
        check("R1 reset flags", {29'd0, err, short_pkt, par_done}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        send_pkt(2'd0, 4, -1, 0, 0);
        send_pkt(2'd1, 6, 2, 0, 1);
        send_pkt(2'd2, 1, 0, 1, 0);
        send_pkt(2'd1, 63, 62, 1, 1);

        // R8: reserved address and invalid decode keep the last header
        cyc(1, 0, 0, 0, 0, 1, 0, {6'd5, 2'b11}, 0, 8'h00, "");
        cyc(0, 1, 0, 0, 0, 1, 0, 8'h3C, 1, {6'd63, 2'd1}, "R8 reserved address ignored");
        cyc(1, 0, 0, 0, 0, 0, 0, {6'd9, 2'b10}, 0, 8'h00, "");
        cyc(0, 1, 0, 0, 0, 1, 0, 8'h3C, 1, {6'd63, 2'd1}, "R8 invalid decode ignored");

        send_pkt(2'd0, 3, -1, 1, 1);

        // R1: reset clears a pending error
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset clears err", {31'd0, err}, 32'd0);
        check("R1 reset clears dout", {24'd0, dout}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        send_pkt(2'd2, 2, 1, 0, 0);

        repeat (2) @(posedge clk);
        #1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule